// File: doc/BRIEF.md
# Cache Diagnostic Access Port with Error Injection

This block gives test and bring-up logic direct read and write access to the tag array and the data array of a small set-associative cache. Each request carries a diagnostic address word and a 64-bit data word. The low bits of the address pick the set, the way and, for the data array, the doubleword within the line. Higher bits of the same address word control error injection, so software can plant known faults without building bad data by hand.

On a tag write, the block computes the tag check bit itself. The valid flag is kept in two copies, and one copy is derived from the other. Two address bits can flip the check bit or make the two valid copies disagree.

On a data write, the block stores the 64-bit word and eight byte-check bits in a separate location. An 8-bit mask in the address inverts chosen check bits. Reads return the stored fields one cycle after the request. The injection bits play no part in choosing the entry.

Both arrays are register files inside the block. The port accepts one request on every cycle.

Top module: `cache_diag_port`

## Requirements
- R1: After reset, `rsp_vld` is 0 and `rsp_rdata` is 0. Every tag entry and every data entry then reads as 0, including the check bits.
- R2: A tag access (`req_arr`=0) addresses entry {way = addr[4:3], set = addr[2:0]}. A tag write stores the tag from wdata[11:0] and valid copy 1 from wdata[14]. A tag read returns {valid1 at bit 14, valid0 at bit 13, check bit at bit 12, tag at bits 11:0}, with bits 63:15 reading as zero.
- R3: The stored tag check bit equals the XOR of all twelve tag bits, XORed with addr[5] (the check-flip bit) of the write request.
- R4: The stored valid copy 0 equals wdata[14] XOR addr[6] (the valid-flip bit). The check bit and valid copy 0 supplied in wdata[13:12] are ignored.
- R5: Tag address bits 6:5 do not take part in selecting the entry, on reads or on writes.
- R6: A data access (`req_arr`=1) addresses entry {way = addr[4:3], set = addr[2:0], doubleword = addr[5]}. A data write stores all 64 bits of wdata. A data read with addr[6]=0 returns that word.
- R7: On a data write, check bit i (i = 0..7) is stored as the XOR of wdata[8i+7:8i], XORed with addr[7+i] (the inversion mask). A data read with addr[6]=1 returns the eight check bits in bits 7:0, with bits 63:8 zero.
- R8: On a data access, the select bit addr[6] and the mask bits addr[14:7] do not take part in selecting the entry. A write stores both the word and its check bits whatever addr[6] holds.
- R9: `rsp_vld` is high in exactly the cycle after a read request. A write produces no response and leaves `rsp_rdata` unchanged.
- R10: Requests may arrive on back-to-back cycles. A read in the cycle right after a write to the same entry returns the newly written fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_arr | input | 1 | 0 = tag array, 1 = data array |
| req_addr | input | 16 | Diagnostic address: entry select plus injection and select bits |
| req_wdata | input | 64 | Write data |
| rsp_vld | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 64 | Read data, held until the next read |

## Verification
The assertions check on every cycle the following properties:
- each tag write leaves the check bit and valid copy 0 that R3 and R4 define in the addressed entry;
- each data write leaves the masked byte-check bits that R7 defines;
- a response follows each read and no other request;
- writes never disturb the returned data.

Only the bench's sweeps can show the following:
- that the injection and select bits do not move the entry;
- that every set, way and doubleword is reachable with no aliasing;
- the reset contents;
- write-then-read forwarding on consecutive cycles.

// File: rtl/cache_diag_pkg.sv
package cache_diag_pkg;

  typedef enum logic {
    ARR_TAG  = 1'b0,
    ARR_DATA = 1'b1
  } arr_sel_e;

  // One even-parity bit per byte of a 64-bit word
  function automatic logic [7:0] byte_parity(input logic [63:0] word);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) begin
      p[b] = ^word[8*b +: 8];
    end
    return p;
  endfunction

endpackage

// File: rtl/cache_diag_tag.sv
module cache_diag_tag #(
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int TAG_W  = 12,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata
);
  localparam int IDX_W    = $clog2(SETS);
  localparam int WAY_W    = $clog2(WAYS);
  localparam int ENT_W    = IDX_W + WAY_W;
  localparam int ENTRIES  = WAYS * SETS;
  localparam int EW       = TAG_W + 3;      // {v1, v0, parity, tag}
  localparam int PERR_BIT = ENT_W;
  localparam int VBE_BIT  = ENT_W + 1;

  logic [EW-1:0]    mem [ENTRIES];
  logic [ENT_W-1:0] ent;
  logic [EW-1:0]    new_entry;
  logic [63:0]      rdata_nxt;
  logic             unused_bits;

  // Injection bits sit above the way/index field, so slicing drops them
  assign ent = addr[ENT_W-1:0];
  assign unused_bits = ^{addr[ADDR_W-1:VBE_BIT+1], wdata[63:EW], wdata[TAG_W+1:TAG_W]};

  always_comb begin
    new_entry[TAG_W-1:0] = wdata[TAG_W-1:0];
    new_entry[TAG_W]     = (^wdata[TAG_W-1:0]) ^ addr[PERR_BIT];
    new_entry[TAG_W+1]   = wdata[TAG_W+2] ^ addr[VBE_BIT];
    new_entry[TAG_W+2]   = wdata[TAG_W+2];
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[e] <= '0;
      end else if (wr_en && (ent == ENT_W'(e))) begin
        mem[e] <= new_entry;
      end
    end
  end

  assign rdata_nxt = {{(64-EW){1'b0}}, mem[ent]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rdata_nxt;
    end
  end

  // R3: stored check bit follows the written tag and the flip bit
  p_tag_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(ent)][TAG_W] ==
              ((^$past(wdata[TAG_W-1:0])) ^ $past(addr[PERR_BIT])));

  // R4: valid copy 0 is copy 1 XOR the valid-flip bit
  p_valid_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(ent)][TAG_W+1] ==
              ($past(wdata[TAG_W+2]) ^ $past(addr[VBE_BIT])));

endmodule

// File: rtl/cache_diag_data.sv
module cache_diag_data
  import cache_diag_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int DWORDS = 2,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata
);
  localparam int IDX_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int DW_W    = (DWORDS > 1) ? $clog2(DWORDS) : 1;
  localparam int ENT_W   = IDX_W + WAY_W + DW_W;
  localparam int ENTRIES = WAYS * SETS * DWORDS;
  localparam int SEL_BIT = ENT_W;
  localparam int MASK_LO = ENT_W + 1;

  logic [63:0]      dmem [ENTRIES];
  logic [7:0]       pmem [ENTRIES];
  logic [ENT_W-1:0] ent;
  logic [7:0]       new_par;
  logic [63:0]      rdata_nxt;
  logic             unused_bits;

  assign ent         = addr[ENT_W-1:0];
  assign new_par     = byte_parity(wdata) ^ addr[MASK_LO +: 8];
  assign unused_bits = ^addr[ADDR_W-1:MASK_LO+8];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dmem[e] <= '0;
        pmem[e] <= '0;
      end else if (wr_en && (ent == ENT_W'(e))) begin
        dmem[e] <= wdata;
        pmem[e] <= new_par;
      end
    end
  end

  assign rdata_nxt = addr[SEL_BIT] ? {56'b0, pmem[ent]} : dmem[ent];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rdata_nxt;
    end
  end

  // R7: stored check bits are byte parity XOR the inversion mask
  p_byte_par_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pmem[$past(ent)] ==
              (byte_parity($past(wdata)) ^ $past(addr[MASK_LO +: 8])));

  // R6: stored word equals the written word
  p_data_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dmem[$past(ent)] == $past(wdata));

endmodule

// File: rtl/cache_diag_port.sv
module cache_diag_port
  import cache_diag_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int DWORDS = 2,
  parameter int TAG_W  = 12,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic              req_arr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_vld,
  output logic [63:0]       rsp_rdata
);
  logic     tag_we, tag_re, dat_we, dat_re, rd_req;
  arr_sel_e arr, rsp_arr_q, rsp_arr_nxt;
  logic [63:0] tag_rdata, dat_rdata;

  assign arr    = arr_sel_e'(req_arr);
  assign rd_req = req_vld && !req_wr;
  assign tag_we = req_vld &&  req_wr && (arr == ARR_TAG);
  assign tag_re = rd_req && (arr == ARR_TAG);
  assign dat_we = req_vld &&  req_wr && (arr == ARR_DATA);
  assign dat_re = rd_req && (arr == ARR_DATA);

  cache_diag_tag #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) u_tag (
    .clk(clk), .rst_n(rst_n), .wr_en(tag_we), .rd_en(tag_re),
    .addr(req_addr), .wdata(req_wdata), .rdata(tag_rdata)
  );

  cache_diag_data #(
    .WAYS(WAYS), .SETS(SETS), .DWORDS(DWORDS), .ADDR_W(ADDR_W)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .wr_en(dat_we), .rd_en(dat_re),
    .addr(req_addr), .wdata(req_wdata), .rdata(dat_rdata)
  );

  assign rsp_arr_nxt = rd_req ? arr : rsp_arr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_arr_q <= ARR_TAG;
    end else begin
      rsp_vld   <= rd_req;
      rsp_arr_q <= rsp_arr_nxt;
    end
  end

  assign rsp_rdata = (rsp_arr_q == ARR_DATA) ? dat_rdata : tag_rdata;

  // R9: a response follows every read
  p_rsp_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_vld);

  // R9: no response without a read
  p_no_rsp_else_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_vld);

  // R9: a write leaves the returned data alone
  p_write_keeps_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_wr) |=> $stable(rsp_rdata));

endmodule

// File: tb/cache_diag_port_test.sv
module cache_diag_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_wr, req_arr;
  logic [15:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_vld;
  logic [63:0] rsp_rdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cache_diag_port uut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_arr(req_arr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // Drive one request for one cycle; on return the response is visible
  task automatic req(input logic wr, input logic arr, input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_arr = arr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  function automatic logic [7:0] bpar(input logic [63:0] d);
    logic [7:0] p = '0;
    for (int i = 0; i < 64; i++) p[i/8] = p[i/8] ^ d[i];
    return p;
  endfunction

  function automatic logic [63:0] tag_exp(input logic [11:0] t, input logic v1,
                                          input logic pe, input logic ve);
    logic par = 1'b0;
    for (int i = 0; i < 12; i++) par ^= t[i];
    return {49'b0, v1, v1 ^ ve, par ^ pe, t};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, last;
    logic [11:0] t;
    logic [7:0]  m;
    rst_n = 1'b0; req_vld = 1'b0; req_wr = 1'b0; req_arr = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rsp_vld after reset", {63'b0, rsp_vld}, 64'd0);
    chk("R1 rsp_rdata after reset", rsp_rdata, 64'd0);
    req(1'b0, 1'b0, 16'h0015, '0);
    chk("R1 tag entry zero", rsp_rdata, 64'd0);
    req(1'b0, 1'b1, 16'h0040 | 16'h002b, '0);
    chk("R1 data check bits zero", rsp_rdata, 64'd0);
    req(1'b0, 1'b1, 16'h002b, '0);
    chk("R1 data word zero", rsp_rdata, 64'd0);

    // R2..R5: full sweep of tag entries, four injection patterns
    for (int pat = 0; pat < 4; pat++) begin
      for (int e = 0; e < 32; e++) begin
        t = 12'((e * 157 + pat * 1021 + 5) ^ (e << 7));
        req(1'b1, 1'b0, 16'(e) | 16'(pat << 5),
            {48'hdead_beef_cafe, 1'b0, 1'(pat ^ e), 2'b11, t});
        req(1'b0, 1'b0, 16'(e) | 16'(((~pat) & 3) << 5) | 16'hff80, '0);
        chk($sformatf("R2 R3 R4 R5 tag entry %0d pat %0d", e, pat), rsp_rdata,
            tag_exp(t, 1'(pat ^ e), pat[0], pat[1]));
        chk("R9 rsp_vld on tag read", {63'b0, rsp_vld}, 64'd1);
      end
    end

    // R6..R8: full sweep of data entries
    for (int e = 0; e < 64; e++) begin
      d = {32'(e * 32'h9E3779B1), 32'((e + 3) * 32'h85EBCA6B)};
      m = 8'(e * 29 + 1);
      req(1'b1, 1'b1, 16'(e) | 16'(e[0] << 6) | 16'(m) << 7, d);
      req(1'b0, 1'b1, 16'(e) | 16'(~m) << 7, '0);
      chk($sformatf("R6 R8 data word entry %0d", e), rsp_rdata, d);
      req(1'b0, 1'b1, 16'(e) | 16'h0040, '0);
      chk($sformatf("R7 R8 check bits entry %0d", e), rsp_rdata, {56'b0, bpar(d) ^ m});
    end

    // R9: write leaves rdata, no response
    last = rsp_rdata;
    req(1'b1, 1'b1, 16'h0003, 64'h0123_4567_89ab_cdef);
    chk("R9 no rsp on write", {63'b0, rsp_vld}, 64'd0);
    chk("R9 rdata held over write", rsp_rdata, last);

    // R10: back-to-back write then read of the same tag entry
    @(negedge clk);
    req_vld = 1'b1; req_wr = 1'b1; req_arr = 1'b0;
    req_addr = 16'h0027; req_wdata = {49'b0, 1'b1, 2'b00, 12'ha5c};
    @(negedge clk);
    chk("R9 no rsp after write cycle", {63'b0, rsp_vld}, 64'd0);
    req_wr = 1'b0; req_addr = 16'h0007;
    @(negedge clk);
    req_vld = 1'b0;
    chk("R10 back-to-back read", rsp_rdata, tag_exp(12'ha5c, 1'b1, 1'b1, 1'b0));
    chk("R10 rsp_vld", {63'b0, rsp_vld}, 64'd1);
    @(negedge clk);
    chk("R9 rsp_vld single cycle", {63'b0, rsp_vld}, 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule